// File: doc/BRIEF.md
# Register-Driven Serial Peripheral Master

This block is a single-byte SPI master that software drives through two 32-bit registers on a simple word bus. One register holds control and status, and the other holds data. Software places a byte in the data register. It then writes the control register with the start bit set. The controller clocks the byte out on MOSI, most significant bit first, and collects the byte that arrives on MISO at the same time. A busy flag tells software when the received byte can be read back from the data register.

The control word also sets three things that take effect directly:
- the levels of three chip-select pins;
- a divider that sets the serial clock rate from the reference clock;
- an internal loopback path that feeds the outgoing serial bit back into the receiver instead of MISO.

The clock polarity and the sampling phase are fixed when the block is built, through the parameters `CPOL` and `CPHA`.

Top module: `spi_regmaster`

## Requirements
- R1: Out of reset:
  - the control register reads 0x00000015;
  - all chip-select pins are high;
  - sclk sits at the CPOL level;
  - the data register reads zero.
- R2: The control/status register is at byte offset 0x0 and the data register is at offset 0x4. Any other offset reads as zero, and a write to it changes nothing.
- R3: A control write with bit 1 set, made while idle, starts one 8-bit transfer. The transfer sends bits 7:0 of the last data-register write on MOSI, most significant bit first.
- R4: Control bit 1 reads as busy. Busy is 1 from the clock after the start write, for exactly 16·(d+1) reference clocks, and then reads 0.
- R5: Once busy clears, bits 7:0 of the data register hold the byte sampled from MISO, first bit received in bit 7. Bits 31:8 read zero.
- R6: Chip-select pin n follows control bit 2n (bits 0, 2 and 4), and the pin level equals the bit value. Those bits read back what was written.
- R7: Control bits 31:27 hold the divider d. Each sclk half-period lasts d+1 reference clocks, and each transfer produces exactly 16 sclk transitions.
- R8: When control bit 3 is set, the received byte equals the transmitted byte whatever MISO carries. MOSI is still driven with the outgoing data.
- R9: A control write with bit 1 clear updates the chip selects, the loopback bit and the divider, and starts no transfer: busy stays 0 and sclk does not move.
- R10: Control bits 26:5 and bit 1 (when idle) read as zero. Bits that are written are read back in place.
- R11: sclk idles at CPOL and returns to CPOL when a transfer ends. With CPHA=0 the master samples on leading sclk edges; with CPHA=1 it samples on trailing edges.
- R12: A control write while busy is ignored. The chip selects, divider and loopback keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | Write enable for the access |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_lvl | output | NUM_CS | Chip-select pin levels |

## Verification
The bench builds the block with CPOL=1 and CPHA=1, so sclk idles high. In this mode the master updates MOSI on falling edges and samples on rising trailing edges. It is the opposite of the default mode, so it exercises both the polarity inversion and the edge that skips the first shift. Runs at divider values 0, 1 and 2 show whether the busy window scales as 16·(d+1). A loopback transfer with MISO held at all ones shows that the receive path ignores the pin while MOSI still carries the byte to the slave model.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;
  localparam int REG_W     = 32;
  localparam int START_BIT = 1;
  localparam int LOOP_BIT  = 3;
  localparam logic [REG_W-1:0] CTRL_RST = 32'h0000_0015;
  localparam int CTRL_OFS  = 0;
  localparam int DATA_OFS  = 4;
endpackage

// File: rtl/spi_rm_regs.sv
module spi_rm_regs
  import spi_rm_pkg::*;
#(
  parameter int NUM_CS = 3,
  parameter int DIV_W  = 5,
  parameter int BITS   = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              busy,
  input  logic [BITS-1:0]   rx_byte,
  output logic [REG_W-1:0]  rdata,
  output logic [NUM_CS-1:0] cs_lvl,
  output logic              loop_en,
  output logic [DIV_W-1:0]  div,
  output logic              start,
  output logic [BITS-1:0]   tx_byte
);
  localparam int DIV_LSB = REG_W - DIV_W;

  logic              hit_ctrl, hit_data, ctrl_wr, data_wr;
  logic [NUM_CS-1:0] cs_q, cs_d, cs_pick;
  logic              loop_q, loop_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [BITS-1:0]   tx_q, tx_d;
  logic [REG_W-1:0]  ctrl_rd;
  logic              unused_wdata;

  assign unused_wdata = ^wdata;
  assign hit_ctrl = (addr == ADDR_W'(CTRL_OFS));
  assign hit_data = (addr == ADDR_W'(DATA_OFS));
  assign ctrl_wr  = sel & we & hit_ctrl & ~busy;
  assign data_wr  = sel & we & hit_data;
  assign start    = ctrl_wr & wdata[START_BIT];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs_pick
    assign cs_pick[i] = wdata[2*i];
  end

  always_comb begin
    cs_d   = cs_q;
    loop_d = loop_q;
    div_d  = div_q;
    tx_d   = tx_q;
    if (ctrl_wr) begin
      cs_d   = cs_pick;
      loop_d = wdata[LOOP_BIT];
      div_d  = wdata[REG_W-1:DIV_LSB];
    end
    if (data_wr) begin
      tx_d = wdata[BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= '1;
      loop_q <= 1'b0;
      div_q  <= '0;
      tx_q   <= '0;
    end else begin
      cs_q   <= cs_d;
      loop_q <= loop_d;
      div_q  <= div_d;
      tx_q   <= tx_d;
    end
  end

  always_comb begin
    ctrl_rd = '0;
    for (int i = 0; i < NUM_CS; i++) ctrl_rd[2*i] = cs_q[i];
    ctrl_rd[START_BIT]           = busy;
    ctrl_rd[LOOP_BIT]            = loop_q;
    ctrl_rd[REG_W-1:DIV_LSB]     = div_q;
  end

  always_comb begin
    rdata = '0;
    if (hit_ctrl)      rdata = ctrl_rd;
    else if (hit_data) rdata[BITS-1:0] = rx_byte;
  end

  assign cs_lvl  = cs_q;
  assign loop_en = loop_q;
  assign div     = div_q;
  assign tx_byte = tx_q;
endmodule

// File: rtl/spi_rm_clkdiv.sv
module spi_rm_clkdiv #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run & (cnt_q == div);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_rm_shift.sv
module spi_rm_shift #(
  parameter bit CPOL = 1'b0,
  parameter bit CPHA = 1'b0,
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            tick,
  input  logic [BITS-1:0] tx_byte,
  input  logic            loop_en,
  input  logic            miso,
  output logic            busy,
  output logic            sclk,
  output logic            mosi,
  output logic [BITS-1:0] rx_byte
);
  localparam int EDGES  = 2 * BITS;
  localparam int EDGE_W = $clog2(EDGES);

  logic              busy_q, busy_d;
  logic              sclk_q, sclk_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic [BITS-1:0]   tx_q, tx_d, rx_q, rx_d;
  logic              leading, last_edge, sample_now, shift_now, din;

  assign leading   = ~edge_q[0];
  assign last_edge = (edge_q == EDGE_W'(EDGES - 1));
  assign din       = loop_en ? tx_q[BITS-1] : miso;

  if (CPHA) begin : g_pha1
    assign sample_now = ~leading;
    assign shift_now  = leading & (edge_q != '0);
  end else begin : g_pha0
    assign sample_now = leading;
    assign shift_now  = ~leading;
  end

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    edge_d = edge_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    if (start) begin
      busy_d = 1'b1;
      sclk_d = CPOL;
      edge_d = '0;
      tx_d   = tx_byte;
    end else if (busy_q && tick) begin
      sclk_d = ~sclk_q;
      edge_d = edge_q + 1'b1;
      if (sample_now) rx_d = {rx_q[BITS-2:0], din};
      if (shift_now)  tx_d = {tx_q[BITS-2:0], 1'b0};
      if (last_edge)  busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= CPOL;
      edge_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      edge_q <= edge_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign busy    = busy_q;
  assign sclk    = sclk_q;
  assign mosi    = tx_q[BITS-1];
  assign rx_byte = rx_q;
endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
  import spi_rm_pkg::*;
#(
  parameter bit CPOL   = 1'b0,
  parameter bit CPHA   = 1'b0,
  parameter int NUM_CS = 3,
  parameter int DIV_W  = 5,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_lvl
);
  localparam int BITS = 8;

  logic             rst_meta, rst_sync_n;
  logic             busy_w, start_w, loop_w, tick_w;
  logic [DIV_W-1:0] div_val;
  logic [BITS-1:0]  tx_w, rx_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  spi_rm_regs #(.NUM_CS(NUM_CS), .DIV_W(DIV_W), .BITS(BITS), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_sync_n), .sel(reg_sel), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .busy(busy_w), .rx_byte(rx_w), .rdata(reg_rdata),
    .cs_lvl(cs_lvl), .loop_en(loop_w), .div(div_val), .start(start_w), .tx_byte(tx_w)
  );

  spi_rm_clkdiv #(.DIV_W(DIV_W)) div_i (
    .clk(clk), .rst_n(rst_sync_n), .run(busy_w), .div(div_val), .tick(tick_w)
  );

  spi_rm_shift #(.CPOL(CPOL), .CPHA(CPHA), .BITS(BITS)) shift_i (
    .clk(clk), .rst_n(rst_sync_n), .start(start_w), .tick(tick_w), .tx_byte(tx_w),
    .loop_en(loop_w), .miso(miso), .busy(busy_w), .sclk(sclk), .mosi(mosi), .rx_byte(rx_w)
  );
endmodule

// File: rtl/spi_rm_chk.sv
module spi_rm_chk #(
  parameter bit CPOL   = 1'b0,
  parameter int NUM_CS = 3,
  parameter int DIV_W  = 5,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              sclk,
  input logic [NUM_CS-1:0] cs_lvl,
  input logic [DIV_W-1:0]  div,
  input logic              reg_sel,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata
);
  localparam int CNT_W = DIV_W + 6;
  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  // R11
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == CPOL);

  // R7
  sclk_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) |-> $past(busy));

  // R12
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cs_lvl));

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_we && reg_addr == '0 && reg_wdata[1] && !busy) |=> busy);

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_cnt == CNT_W'(16 * (int'(div) + 1)));
endmodule

bind spi_regmaster spi_rm_chk #(.CPOL(CPOL), .NUM_CS(NUM_CS), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .busy(busy_w), .sclk(sclk), .cs_lvl(cs_lvl),
  .div(div_val), .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata)
);

// File: tb/spi_regmaster_tb_top.sv
module spi_regmaster_tb_top;
  localparam bit TB_CPOL = 1'b1;
  localparam bit TB_CPHA = 1'b1;

  logic        clk, rst_n, reg_sel, reg_we, sclk, mosi, miso;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [2:0]  cs_lvl;

  int total, bad, sclk_edges;
  logic [7:0] s_out, s_rx;
  int s_idx;

  typedef struct {
    logic [7:0] rx;
    logic [7:0] srx;
    int         cyc;
    logic [2:0] cs;
  } exp_t;
  exp_t exp_q[$];

  logic [31:0] got_data;
  logic [7:0]  got_srx;
  int          got_cyc, got_edges;
  logic        got_sclk;
  logic [2:0]  got_cs;
  event        res_ev;

  spi_regmaster #(.CPOL(TB_CPOL), .CPHA(TB_CPHA)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_lvl(cs_lvl)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(sclk) sclk_edges++;

  task automatic slave_sample();
    s_rx = {s_rx[6:0], mosi};
    s_idx++;
  endtask
  always @(posedge sclk) if (TB_CPOL == TB_CPHA) slave_sample();
  always @(negedge sclk) if (TB_CPOL != TB_CPHA) slave_sample();
  always_comb miso = (s_idx < 8) ? s_out[7 - s_idx] : 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    forever begin
      bus_read(4'h0, v);
      if (!v[1]) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_xfer(input logic [31:0] txw, input logic [7:0] sl, input bit lp,
                         input int d, input logic [4:0] csb);
    exp_t e;
    logic [31:0] ctrl;
    int e0;
    bus_write(4'h4, txw);
    s_out = sl; s_idx = 0; s_rx = 8'h00;
    e.rx  = lp ? txw[7:0] : sl;
    e.srx = txw[7:0];
    e.cyc = 16 * (d + 1);
    e.cs  = {csb[4], csb[2], csb[0]};
    exp_q.push_back(e);
    ctrl = (32'(d) << 27) | (32'(lp) << 3) | {27'h0, csb} | 32'h2;
    e0 = sclk_edges;
    bus_write(4'h0, ctrl);
    wait_idle(got_cyc);
    got_edges = sclk_edges - e0;
    bus_read(4'h4, got_data);
    got_srx  = s_rx;
    got_sclk = sclk;
    got_cs   = cs_lvl;
    -> res_ev;
    #2;
  endtask

  initial begin
    forever begin
      @(res_ev);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 queue empty", 0, 1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(got_data == {24'h0, e.rx}, "R5/R8 received byte", got_data, {24'h0, e.rx});
        chk(got_srx == e.srx, "R3 MOSI byte at slave", got_srx, e.srx);
        chk(got_cyc == e.cyc, "R4 busy length", got_cyc, e.cyc);
        chk(got_edges == 16, "R7 sclk transitions", got_edges, 16);
        chk(got_sclk == TB_CPOL, "R11 sclk idle level", got_sclk, TB_CPOL);
        chk(got_cs == e.cs, "R6 chip-select pins", got_cs, e.cs);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int e0, n;
    total = 0; bad = 0; sclk_edges = 0;
    s_out = 8'h00; s_rx = 8'h00; s_idx = 8;
    rst_n = 1'b0; reg_sel = 1'b0; reg_we = 1'b0; reg_addr = 4'h0; reg_wdata = 32'h0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(4'h0, v);  chk(v == 32'h15, "R1 ctrl reset", v, 32'h15);
    bus_read(4'h4, v);  chk(v == 32'h0, "R1 data reset", v, 32'h0);
    chk(cs_lvl == 3'b111, "R1 cs reset", {29'h0, cs_lvl}, 32'h7);
    chk(sclk == TB_CPOL, "R1 sclk reset", {31'h0, sclk}, {31'h0, TB_CPOL});

    // R9 / R10 control write without start
    e0 = sclk_edges;
    bus_write(4'h0, 32'hFFFF_FFFD);
    repeat (40) @(negedge clk);
    bus_read(4'h0, v);
    chk(v == 32'hF800_001D, "R10 undefined bits zero", v, 32'hF800_001D);
    chk(sclk_edges == e0, "R9 no sclk activity", sclk_edges - e0, 0);
    chk(cs_lvl == 3'b111, "R9 cs update", {29'h0, cs_lvl}, 32'h7);
    bus_write(4'h0, 32'h0000_0004);
    bus_read(4'h0, v);
    chk(v == 32'h4, "R9 fields updated, not busy", v, 32'h4);
    chk(cs_lvl == 3'b010, "R6 cs1 high only", {29'h0, cs_lvl}, 32'h2);

    // R2 other offsets
    bus_write(4'h8, 32'hFFFF_FFFF);
    bus_read(4'h8, v);  chk(v == 32'h0, "R2 unmapped reads zero", v, 32'h0);
    bus_read(4'h0, v);  chk(v == 32'h4, "R2 unmapped write ignored", v, 32'h4);

    // transfers
    do_xfer(32'h0000_00A5, 8'h3C, 1'b0, 0, 5'h14);
    do_xfer(32'hFFFF_FF81, 8'h7E, 1'b0, 2, 5'h11);
    do_xfer(32'h0000_005A, 8'hFF, 1'b1, 1, 5'h15);
    do_xfer(32'h0000_0000, 8'h01, 1'b0, 0, 5'h05);

    // R12 control write during a transfer
    bus_write(4'h4, 32'h0000_00C3);
    s_out = 8'h99; s_idx = 0;
    bus_write(4'h0, (32'd1 << 27) | 32'h0000_0017);
    repeat (3) @(negedge clk);
    bus_write(4'h0, 32'h0000_0000);
    wait_idle(n);
    bus_read(4'h0, v);
    chk(v == 32'h0800_0015, "R12 ctrl unchanged by busy write", v, 32'h0800_0015);
    chk(cs_lvl == 3'b111, "R12 cs pins unchanged", {29'h0, cs_lvl}, 32'h7);
    bus_read(4'h4, v);
    chk(v == 32'h0000_0099, "R12 transfer completed", v, 32'h99);

    #20;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule